// File: doc/BRIEF.md
# Boot SPI Flash Emulator

This block sits on the serial bus that a target processor uses to fetch its boot code. A route control chooses where the target's bus goes. With the route cleared, chip-select, clock and data pass straight to a physical SPI NOR flash, and the flash's data output comes back to the target. With the route set, the physical flash is held deselected. An internal byte-wide memory then answers the target's read commands. The memory has `2**MEM_AW` bytes. A full-size build sets `MEM_AW = 16`, which gives a 64 KiB region. The default is smaller, so that plain elaboration stays light.

A host sees the same memory as a second, independent port. It can read the image and patch it at any time. The target normally sits powered down while this happens. The host also reaches a small register space. In it the host controls the route and a power-enable output wired to the target's power switch. It can also read a counter of accepted target read commands. A script can therefore patch the image, cycle power and confirm that the target fetched from the emulator.

The serial slave oversamples the target's clock with the system clock. The target clock's high and low phases must each last at least four system clock cycles. Target clock rates that approach or exceed the system clock, including 104 MHz, are not supported on this path. Targets that raise their bus clock that far must be switched to the physical flash before they do so.

Top module: `spiemu_top`

## Requirements
- R1: After reset the route selects the physical flash, the power-enable output is low, the control register reads 0, the access counter reads 0 and the target data output enable is low while chip-select is high.
- R2: With the route set, command 0x03 followed by a 24-bit address (MSB first) returns the byte at that address, then the bytes at following addresses. Data is shifted out MSB first and changes after each falling clock edge. Input bits are sampled on the rising edge (SPI mode 0).
- R3: With the route set, command 0x0B takes a 24-bit address and then 8 dummy clocks, after which data is returned exactly as for 0x03.
- R4: Only the low `MEM_AW` address bits are used. Address bits above them are ignored, and a sequential read past the last byte continues at address 0.
- R5: Any other command byte makes the emulator drive the target data line high, with its output enable on, for every following clock until chip-select is released. Such a command does not change the access counter.
- R6: The target data output enable is low whenever chip-select has been high for at least three system clock cycles. With the route set, the output enable is high during the data phase of a read.
- R7: With the route cleared, the flash chip-select follows the target chip-select, the flash clock and data-in follow the target's, and the target data line carries the flash data output. With the route set, the flash chip-select stays high even while the target chip-select is low.
- R8: A host write to memory address A (host address bit `MEM_AW` = 0) changes the byte that the host reads back at A. It also changes the byte that a following target read of A returns. Host read data appears the cycle after the request.
- R9: A host write to register offset 0 (host address bit `MEM_AW` = 1) sets the route from data bit 0 and the power-enable output from data bit 1. Reading offset 0 returns {6'b0, power, route}. The power output changes only on such a write.
- R10: A route change written while the target chip-select is low is discarded: the route and the readback keep their old value. The power bit of the same write still takes effect.
- R11: The access counter increments by one for each accepted 0x03 or 0x0B command. It wraps modulo `2**CNT_W`. The host reads it least significant byte first at register offsets 1, 2 and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | MEM_AW+1 | Top bit selects registers (1) or memory (0); low bits give the byte address or register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after a read |
| tgt_cs_n | input | 1 | Target chip-select, active low |
| tgt_sck | input | 1 | Target serial clock |
| tgt_mosi | input | 1 | Target serial data out |
| tgt_miso | output | 1 | Serial data to target |
| tgt_miso_oe | output | 1 | Output enable for tgt_miso |
| flash_cs_n | output | 1 | Physical flash chip-select |
| flash_sck | output | 1 | Physical flash clock |
| flash_mosi | output | 1 | Physical flash data in |
| flash_miso | input | 1 | Physical flash data out |
| tgt_pwr_en | output | 1 | Target power switch enable |

## Verification
The bench builds the block with `MEM_AW = 8` and `CNT_W = 16`. The 256-byte region means that wrap at the top of memory, and the discarding of high address bits, are reached by reads that start near 0xFF with nonzero upper address bytes. The bench fills the whole region from the host port, so every byte the target can fetch has a known value. A sixteen-bit counter gives two readable counter bytes at offsets 1 and 2.

// File: rtl/spiemu_pkg.sv
package spiemu_pkg;

    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_FAST_READ = 8'h0B;

    localparam int ADDR_BITS  = 24;
    localparam int DUMMY_BITS = 8;

    localparam int REG_CTRL    = 0;
    localparam int REG_CNT_LSB = 1;
    localparam int CTRL_ROUTE  = 0;
    localparam int CTRL_POWER  = 1;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_BAD
    } phase_e;

endpackage

// File: rtl/spiemu_dpram.sv
module spiemu_dpram #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic [AW-1:0] tgt_addr,
    output logic [7:0]    tgt_rdata,
    input  logic          hst_en,
    input  logic          hst_we,
    input  logic [AW-1:0] hst_addr,
    input  logic [7:0]    hst_wdata,
    output logic [7:0]    hst_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] tgt_rdata_q;
    logic [7:0] hst_rdata_q;

    // Target side: read-only, registered every cycle.
    always_ff @(posedge clk) begin
        tgt_rdata_q <= mem_q[tgt_addr];
    end

    // Host side: read-write on strobe.
    always_ff @(posedge clk) begin
        if (hst_en) begin
            if (hst_we) begin
                mem_q[hst_addr] <= hst_wdata;
            end
            hst_rdata_q <= mem_q[hst_addr];
        end
    end

    assign tgt_rdata = tgt_rdata_q;
    assign hst_rdata = hst_rdata_q;

endmodule

// File: rtl/spiemu_slave.sv
module spiemu_slave
    import spiemu_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          miso,
    output logic          miso_oe,
    output logic          cmd_ok
);
    localparam int NB_W = $clog2(ADDR_BITS);

    typedef struct packed {
        logic [1:0]      cs_s;
        logic [2:0]      sck_s;
        logic [1:0]      mosi_s;
        phase_e          ph;
        logic [7:0]      sh;
        logic [NB_W-1:0] nb;
        logic            fast;
        logic [AW-1:0]   addr;
        logic [6:0]      ob;
        logic [2:0]      ob_n;
        logic            miso;
        logic            hit;
    } slave_t;

    slave_t q, d;

    logic       rise, fall, bit_in, selected;
    logic [7:0] byte_in;

    always_comb begin
        d        = q;
        d.hit    = 1'b0;
        d.cs_s   = {q.cs_s[0], cs_n | ~enable};
        d.sck_s  = {q.sck_s[1:0], sck};
        d.mosi_s = {q.mosi_s[0], mosi};

        rise     = q.sck_s[1] & ~q.sck_s[2];
        fall     = ~q.sck_s[1] & q.sck_s[2];
        bit_in   = q.mosi_s[1];
        selected = ~q.cs_s[1];
        byte_in  = {q.sh[6:0], bit_in};

        if (!selected) begin
            d.ph   = PH_CMD;
            d.nb   = '0;
            d.ob_n = '0;
        end else if (rise) begin
            unique case (q.ph)
                PH_CMD: begin
                    d.sh = byte_in;
                    d.nb = q.nb + 1'b1;
                    if (q.nb == NB_W'(7)) begin
                        d.nb = '0;
                        if (byte_in == OP_READ || byte_in == OP_FAST_READ) begin
                            d.ph   = PH_ADDR;
                            d.fast = (byte_in == OP_FAST_READ);
                            d.hit  = 1'b1;
                        end else begin
                            d.ph = PH_BAD;
                        end
                    end
                end
                PH_ADDR: begin
                    d.addr = {q.addr[AW-2:0], bit_in};
                    d.nb   = q.nb + 1'b1;
                    if (q.nb == NB_W'(ADDR_BITS - 1)) begin
                        d.nb   = '0;
                        d.ob_n = '0;
                        d.ph   = q.fast ? PH_DUMMY : PH_DATA;
                    end
                end
                PH_DUMMY: begin
                    d.nb = q.nb + 1'b1;
                    if (q.nb == NB_W'(DUMMY_BITS - 1)) begin
                        d.nb = '0;
                        d.ph = PH_DATA;
                    end
                end
                default: ;
            endcase
        end else if (fall && q.ph == PH_DATA) begin
            if (q.ob_n == 3'd0) begin
                d.miso = rd_data[7];
                d.ob   = rd_data[6:0];
                d.addr = q.addr + 1'b1;
            end else begin
                d.miso = q.ob[6];
                d.ob   = {q.ob[5:0], 1'b0};
            end
            d.ob_n = q.ob_n + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_s <= 2'b11;
            q.ph   <= PH_CMD;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign miso    = (q.ph == PH_BAD) ? 1'b1 : q.miso;
    assign miso_oe = selected & (q.ph == PH_DATA || q.ph == PH_BAD);
    assign cmd_ok  = q.hit;

    // R2/R3: the data phase is only ever entered after the address or dummy phase.
    assert_data_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DATA && $past(q.ph) != PH_DATA) |->
        ($past(q.ph) == PH_ADDR || $past(q.ph) == PH_DUMMY));

    // R5: an unsupported command is left only after chip-select is released.
    assert_bad_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.ph) == PH_BAD && q.ph != PH_BAD) |-> $past(q.cs_s[1]));

endmodule

// File: rtl/spiemu_hostregs.sv
module spiemu_hostregs
    import spiemu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_en,
    input  logic             host_we,
    input  logic             is_reg,
    input  logic [REG_W-1:0] reg_off,
    input  logic [1:0]       ctrl_wdata,
    input  logic             tgt_cs_n,
    input  logic             cmd_ok,
    input  logic [7:0]       mem_rdata,
    output logic [7:0]       host_rdata,
    output logic             route_emu,
    output logic             pwr_en
);
    localparam int CNT_BYTES = (CNT_W + 7) / 8;

    typedef struct packed {
        logic             route;
        logic             pwr;
        logic [CNT_W-1:0] cnt;
        logic             reg_sel;
        logic [7:0]       reg_rd;
    } regs_t;

    regs_t q, d;

    logic [8*CNT_BYTES-1:0] cnt_pad;
    logic [7:0]             rd_mux;

    always_comb begin
        cnt_pad             = '0;
        cnt_pad[CNT_W-1:0]  = q.cnt;
        rd_mux              = 8'h00;
        if (reg_off == REG_W'(REG_CTRL)) begin
            rd_mux[CTRL_ROUTE] = q.route;
            rd_mux[CTRL_POWER] = q.pwr;
        end
        for (int k = 0; k < CNT_BYTES; k++) begin
            if (reg_off == REG_W'(REG_CNT_LSB + k)) begin
                rd_mux = cnt_pad[8*k +: 8];
            end
        end

        d = q;
        if (cmd_ok) begin
            d.cnt = q.cnt + 1'b1;
        end
        if (host_en) begin
            d.reg_sel = is_reg;
            if (is_reg) begin
                d.reg_rd = rd_mux;
                if (host_we && reg_off == REG_W'(REG_CTRL)) begin
                    d.pwr = ctrl_wdata[CTRL_POWER];
                    if (tgt_cs_n) begin
                        d.route = ctrl_wdata[CTRL_ROUTE];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign host_rdata = q.reg_sel ? q.reg_rd : mem_rdata;
    assign route_emu  = q.route;
    assign pwr_en     = q.pwr;

    // R10: the route only moves after a cycle with chip-select inactive.
    assert_route_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.route) |-> $past(tgt_cs_n));

    // R9: power output moves only on a host register write.
    assert_pwr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pwr) |-> $past(host_en && host_we && is_reg));

    // R11: the counter advances by exactly one when it moves.
    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cnt) |-> (q.cnt == $past(q.cnt) + 1'b1));

endmodule

// File: rtl/spiemu_top.sv
module spiemu_top
    import spiemu_pkg::*;
#(
    parameter int MEM_AW = 12,
    parameter int CNT_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_en,
    input  logic            host_we,
    input  logic [MEM_AW:0] host_addr,
    input  logic [7:0]      host_wdata,
    output logic [7:0]      host_rdata,
    input  logic            tgt_cs_n,
    input  logic            tgt_sck,
    input  logic            tgt_mosi,
    output logic            tgt_miso,
    output logic            tgt_miso_oe,
    output logic            flash_cs_n,
    output logic            flash_sck,
    output logic            flash_mosi,
    input  logic            flash_miso,
    output logic            tgt_pwr_en
);
    localparam int CNT_BYTES = (CNT_W + 7) / 8;
    localparam int REG_W     = $clog2(CNT_BYTES + 1);

    logic [MEM_AW-1:0] emu_addr;
    logic [7:0]        emu_rdata;
    logic [7:0]        mem_hrdata;
    logic              emu_miso, emu_oe, emu_hit;
    logic              route_emu;
    logic              is_reg;

    assign is_reg = host_addr[MEM_AW];

    spiemu_dpram #(.AW(MEM_AW)) i_mem (
        .clk       (clk),
        .tgt_addr  (emu_addr),
        .tgt_rdata (emu_rdata),
        .hst_en    (host_en & ~is_reg),
        .hst_we    (host_we),
        .hst_addr  (host_addr[MEM_AW-1:0]),
        .hst_wdata (host_wdata),
        .hst_rdata (mem_hrdata)
    );

    spiemu_slave #(.AW(MEM_AW)) i_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (route_emu),
        .cs_n    (tgt_cs_n),
        .sck     (tgt_sck),
        .mosi    (tgt_mosi),
        .rd_data (emu_rdata),
        .rd_addr (emu_addr),
        .miso    (emu_miso),
        .miso_oe (emu_oe),
        .cmd_ok  (emu_hit)
    );

    spiemu_hostregs #(.CNT_W(CNT_W), .REG_W(REG_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_en    (host_en),
        .host_we    (host_we),
        .is_reg     (is_reg),
        .reg_off    (host_addr[REG_W-1:0]),
        .ctrl_wdata (host_wdata[1:0]),
        .tgt_cs_n   (tgt_cs_n),
        .cmd_ok     (emu_hit),
        .mem_rdata  (mem_hrdata),
        .host_rdata (host_rdata),
        .route_emu  (route_emu),
        .pwr_en     (tgt_pwr_en)
    );

    always_comb begin
        flash_sck   = tgt_sck;
        flash_mosi  = tgt_mosi;
        flash_cs_n  = route_emu ? 1'b1 : tgt_cs_n;
        tgt_miso    = route_emu ? emu_miso : flash_miso;
        tgt_miso_oe = route_emu ? emu_oe : ~tgt_cs_n;
    end

    // R6: three cycles of inactive chip-select leave the data line undriven.
    assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_cs_n && $past(tgt_cs_n) && $past(tgt_cs_n, 2)) |-> !tgt_miso_oe);

endmodule

// File: tb/test_spiemu_top.sv
module test_spiemu_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_en = 1'b0, host_we = 1'b0;
    logic [AW:0]   host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          tgt_cs_n = 1'b1, tgt_sck = 1'b0, tgt_mosi = 1'b0;
    logic          tgt_miso, tgt_miso_oe;
    logic          flash_cs_n, flash_sck, flash_mosi;
    logic          flash_miso = 1'b0;
    logic          tgt_pwr_en;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    logic [7:0] model [256];
    int  exp_cnt = 0;

    always #10 clk = ~clk;

    spiemu_top #(.MEM_AW(AW), .CNT_W(16)) i_spiemu_top (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tgt_cs_n(tgt_cs_n), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
        .tgt_miso(tgt_miso), .tgt_miso_oe(tgt_miso_oe),
        .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_mosi(flash_mosi),
        .flash_miso(flash_miso), .tgt_pwr_en(tgt_pwr_en)
    );

    // {command, 24-bit address, byte count}
    localparam logic [35:0] VECS [10] = '{
        {8'h03, 24'h000000, 4'd2},
        {8'h03, 24'h000041, 4'd4},
        {8'h0B, 24'h000080, 4'd3},
        {8'h03, 24'h0000FE, 4'd4},
        {8'h0B, 24'hABCDFF, 4'd3},
        {8'h9F, 24'h000000, 4'd2},
        {8'h03, 24'h12345C, 4'd1},
        {8'h05, 24'h000000, 4'd1},
        {8'h0B, 24'h0000FF, 4'd2},
        {8'h03, 24'h000003, 4'd3}
    };

    function automatic logic [7:0] fill_val(input int i);
        return 8'((i * 37 + 11) ^ (i >> 2));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW:0] a, input logic [7:0] v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [AW:0] a, output logic [7:0] v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_en = 1'b0;
        v = host_rdata;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            tgt_sck = 1'b0; tgt_mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = tgt_miso;
            oe_all &= tgt_miso_oe;
            tgt_sck = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic spi_xact(input logic [7:0] cmd, input logic [23:0] adr, input int len);
        logic [7:0] rx;
        bit oe_ok, good;
        good = (cmd == 8'h03 || cmd == 8'h0B);
        @(negedge clk); tgt_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        spi_byte(cmd, rx, oe_ok);
        if (good) begin
            spi_byte(adr[23:16], rx, oe_ok);
            spi_byte(adr[15:8], rx, oe_ok);
            spi_byte(adr[7:0], rx, oe_ok);
            if (cmd == 8'h0B) spi_byte(8'h00, rx, oe_ok);
            exp_cnt++;
        end
        for (int k = 0; k < len; k++) begin
            spi_byte(8'h00, rx, oe_ok);
            if (good) begin
                // R2/R3/R4: sequential bytes, low address bits only, wrap at top
                chk(rx == model[(int'(adr[7:0]) + k) % 256] && oe_ok,
                    "R2/R3/R4 read data", rx, model[(int'(adr[7:0]) + k) % 256]);
            end else begin
                chk(rx == 8'hFF && oe_ok, "R5 unsupported command drives high", rx, 8'hFF);
            end
        end
        @(negedge clk); tgt_sck = 1'b0;
        repeat (4) @(negedge clk);
        tgt_cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(tgt_miso_oe == 1'b0, "R6 output enable off after deselect", tgt_miso_oe, 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(tgt_pwr_en == 1'b0, "R1 power low", tgt_pwr_en, 0);
        chk(tgt_miso_oe == 1'b0, "R1 oe low", tgt_miso_oe, 0);
        host_read({1'b1, 8'd0}, v);
        chk(v == 8'h00, "R1 control reads 0", v, 0);
        host_read({1'b1, 8'd1}, v);
        chk(v == 8'h00, "R1 counter reads 0", v, 0);

        // R7: pass-through with route cleared
        @(negedge clk); tgt_cs_n = 1'b0; tgt_sck = 1'b1; tgt_mosi = 1'b1; flash_miso = 1'b1;
        #1;
        chk(flash_cs_n == 1'b0 && flash_sck && flash_mosi, "R7 pass-through to flash",
            {flash_cs_n, flash_sck, flash_mosi}, 3'b011);
        chk(tgt_miso == 1'b1 && tgt_miso_oe, "R7 flash data to target", tgt_miso, 1);
        flash_miso = 1'b0; #1;
        chk(tgt_miso == 1'b0, "R7 flash data low to target", tgt_miso, 0);
        @(negedge clk); tgt_cs_n = 1'b1; tgt_sck = 1'b0; tgt_mosi = 1'b0;
        repeat (4) @(negedge clk);

        // Fill the whole region from the host side.
        for (int i = 0; i < 256; i++) begin
            model[i] = fill_val(i);
            host_write({1'b0, 8'(i)}, model[i]);
        end
        host_read({1'b0, 8'h77}, v);
        chk(v == model[8'h77], "R8 host readback", v, model[8'h77]);

        // R9: route to emulator and power on
        host_write({1'b1, 8'd0}, 8'h03);
        chk(tgt_pwr_en == 1'b1, "R9 power on", tgt_pwr_en, 1);
        host_read({1'b1, 8'd0}, v);
        chk(v == 8'h03, "R9 control readback", v, 3);
        @(negedge clk); tgt_cs_n = 1'b0; #1;
        chk(flash_cs_n == 1'b1, "R7 flash held deselected", flash_cs_n, 1);
        @(negedge clk); tgt_cs_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table
        for (int n = 0; n < 10; n++) begin
            spi_xact(VECS[n][35:28], VECS[n][27:4], int'(VECS[n][3:0]));
        end

        // R11: counter after the table (unsupported commands not counted)
        host_read({1'b1, 8'd1}, v);
        chk(v == 8'(exp_cnt), "R11 counter low byte", v, exp_cnt);
        host_read({1'b1, 8'd2}, v);
        chk(v == 8'h00, "R11 counter high byte", v, 0);

        // R8: host patch seen by target
        host_write({1'b0, 8'h41}, 8'hC3);
        model[8'h41] = 8'hC3;
        host_read({1'b0, 8'h41}, v);
        chk(v == 8'hC3, "R8 patched byte readback", v, 8'hC3);
        spi_xact(8'h03, 24'h000041, 1);
        host_read({1'b1, 8'd1}, v);
        chk(v == 8'(exp_cnt), "R11 counter after patch read", v, exp_cnt);

        // R10: route change discarded while chip-select low, power still applied
        @(negedge clk); tgt_cs_n = 1'b0;
        host_write({1'b1, 8'd0}, 8'h00);
        chk(tgt_pwr_en == 1'b0, "R10 power write still applies", tgt_pwr_en, 0);
        host_read({1'b1, 8'd0}, v);
        chk(v == 8'h01, "R10 route kept while selected", v, 1);
        @(negedge clk); tgt_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        host_write({1'b1, 8'd0}, 8'h02);
        host_read({1'b1, 8'd0}, v);
        chk(v == 8'h02, "R10 route change accepted when idle", v, 2);
        chk(tgt_pwr_en == 1'b1, "R9 power on again", tgt_pwr_en, 1);
        @(negedge clk); tgt_cs_n = 1'b0; flash_miso = 1'b1; #1;
        chk(flash_cs_n == 1'b0 && tgt_miso == 1'b1, "R7 pass-through restored",
            {flash_cs_n, tgt_miso}, 2'b01);
        @(negedge clk); tgt_cs_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule